// File: doc/BRIEF.md
# Byte-Serial Result Port with Busy/Strobe Handshake

This block hands a pair of 32-bit measurement words to a host over an 8-bit parallel bus. The host pulls the fetch line low. The block then waits for the end of the integration cycle in progress, which the `cycleDone` pulse marks. At that moment it copies both words into a snapshot register and raises the busy line. It then puts out eight bytes, one at a time. The strobe line rises once for each byte, and the host latches each byte on that rising edge.

The data pins carry a value only while the active-low output enable is asserted, and float otherwise. When the calibration input (autozero/reset) is held low, any transfer in progress stops. The busy line then stays high while the input is low and for a fixed settling period afterwards. During that time the host knows that no result is available.

Top module: `byteSerialOut`

## Requirements
- R1: While `rstN` or `calibN` is low, and for AZ_CLKS-1 cycles after both are high, `frameBusy` is 1 and `byteStrobe` is 0. After that, `frameBusy` is 0.
- R2: While idle, a high-to-low transition of `fetchN` arms the block. `frameBusy` rises in the cycle after the first `cycleDone` pulse sampled on or after the clock edge that saw the transition. A pulse on that same edge counts. `frameBusy` stays 0 before that pulse.
- R3: Byte order is fixed. Bytes 1 to 4 carry `wordA` and bytes 5 to 8 carry `wordB`, each word most significant byte first.
- R4: Each byte is on the bus for one cycle with `byteStrobe` low before `byteStrobe` rises. It stays unchanged for the whole time `byteStrobe` is high.
- R5: `byteStrobe` is high for exactly HOLD_CLKS cycles per byte and low for at least one cycle between bytes. Each transfer has exactly eight rising edges, and `byteStrobe` is never high while `frameBusy` is low.
- R6: `frameBusy` falls in the same cycle that `byteStrobe` falls after the eighth byte.
- R7: `dataBus` is high impedance while `oeN` is 1. While `oeN` is 0 it carries the current byte. After a transfer, the current byte is the last byte sent.
- R8: A `fetchN` held low after a transfer does not start another transfer. It must go high and then low again.
- R9: A `fetchN` falling edge during calibration or during a transfer is ignored. Driving `calibN` low during a transfer stops it: the next cycle shows `frameBusy` 1 and `byteStrobe` 0.
- R10: The words are captured when the transfer is acknowledged. Changes on `wordA` or `wordB` after that do not alter the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; enters calibration |
| calibN | input | 1 | Active-low autozero/reset request |
| fetchN | input | 1 | Active-low data request; its falling edge arms a transfer |
| oeN | input | 1 | Active-low output enable for `dataBus` |
| cycleDone | input | 1 | One-cycle pulse at the end of each integration cycle |
| wordA | input | 32 | First result word (elapsed-time word) |
| wordB | input | 32 | Second result word (integral word) |
| dataBus | output | 8 | Byte output, high impedance while `oeN` is 1 |
| frameBusy | output | 1 | High while calibrating or while a transfer is in progress |
| byteStrobe | output | 1 | Rises once per byte; the byte is valid on its rising edge |

## Verification
Two events can land on the same clock edge: the fetch falling edge and the end-of-cycle pulse. The bench drives both in the same cycle for one table row. It expects the acknowledge one cycle later, with no extra wait for a second pulse. Other rows put one, three or five cycles between the two events, and the bench checks that busy stays low until the pulse arrives. Calibration is also asserted in the middle of a transfer, and a fetch edge is given while calibration is active. The bench judges these cases by the busy and strobe lines in the next cycle, and by the absence of any later transfer.

// File: rtl/byteSerialOut_pkg.sv
package byteSerialOut_pkg;

  typedef enum logic [2:0] {
    ST_CALIB,
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_HIGH
  } outState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSnap;   // capture both words, rewind to first byte
    logic nextByte;   // step to the following byte
  } outStrobe_t;

endpackage

// File: rtl/byteSerialOut_ctrl.sv
module byteSerialOut_ctrl
  import byteSerialOut_pkg::*;
#(
  parameter int AZ_CLKS   = 8,
  parameter int HOLD_CLKS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       calibN,
  input  logic       fetchN,
  input  logic       cycleDone,
  input  logic       lastByte,
  output outStrobe_t strobes,
  output logic       frameBusy,
  output logic       byteStrobe
);

  localparam int AZ_W   = $clog2(AZ_CLKS + 1);
  localparam int HOLD_W = $clog2(HOLD_CLKS + 1);

  outState_t         state;
  logic [AZ_W-1:0]   azCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              fetchPrev;
  logic              fetchEdge;
  logic              holdDone;
  logic              armed;

  assign fetchEdge = fetchPrev && !fetchN;
  assign holdDone  = (holdCnt == HOLD_W'(HOLD_CLKS - 1));
  assign armed     = (state == ST_WAIT) || ((state == ST_IDLE) && fetchEdge);

  always_comb begin
    strobes          = '0;
    strobes.loadSnap = calibN && armed && cycleDone;
    strobes.nextByte = calibN && (state == ST_HIGH) && holdDone && !lastByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_CALIB;
      azCnt     <= '0;
      holdCnt   <= '0;
      fetchPrev <= 1'b1;
    end else begin
      fetchPrev <= fetchN;
      if (!calibN) begin
        state <= ST_CALIB;
        azCnt <= '0;
      end else begin
        unique case (state)
          ST_CALIB: begin
            if (azCnt == AZ_W'(AZ_CLKS - 1)) state <= ST_IDLE;
            else azCnt <= azCnt + 1'b1;
          end
          ST_IDLE: begin
            if (fetchEdge) state <= cycleDone ? ST_SETUP : ST_WAIT;
          end
          ST_WAIT: begin
            if (cycleDone) state <= ST_SETUP;
          end
          ST_SETUP: begin
            state   <= ST_HIGH;
            holdCnt <= '0;
          end
          ST_HIGH: begin
            if (holdDone) state <= lastByte ? ST_IDLE : ST_SETUP;
            else holdCnt <= holdCnt + 1'b1;
          end
          default: state <= ST_CALIB;
        endcase
      end
    end
  end

  assign frameBusy  = (state == ST_CALIB) || (state == ST_SETUP) || (state == ST_HIGH);
  assign byteStrobe = (state == ST_HIGH);

endmodule

// File: rtl/byteSerialOut_dp.sv
module byteSerialOut_dp
  import byteSerialOut_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  outStrobe_t        strobes,
  input  logic [WORD_W-1:0] wordA,
  input  logic [WORD_W-1:0] wordB,
  output logic [BUS_W-1:0]  curByte,
  output logic              lastByte
);

  localparam int FRAME_W = 2 * WORD_W;
  localparam int BYTES   = FRAME_W / BUS_W;
  localparam int IDX_W   = $clog2(BYTES);

  logic [FRAME_W-1:0] snap;
  logic [IDX_W-1:0]   idx;
  logic [BUS_W-1:0]   lanes [BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snap <= '0;
      idx  <= '0;
    end else if (strobes.loadSnap) begin
      snap <= {wordA, wordB};
      idx  <= '0;
    end else if (strobes.nextByte) begin
      idx  <= idx + 1'b1;
    end
  end

  // lane 0 is the most significant byte of the first word
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lanes[g] = snap[FRAME_W-1-g*BUS_W -: BUS_W];
  end

  assign curByte  = lanes[idx];
  assign lastByte = (idx == IDX_W'(BYTES - 1));

endmodule

// File: rtl/byteSerialOut.sv
module byteSerialOut
  import byteSerialOut_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUS_W     = 8,
  parameter int AZ_CLKS   = 8,
  parameter int HOLD_CLKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calibN,
  input  logic              fetchN,
  input  logic              oeN,
  input  logic              cycleDone,
  input  logic [WORD_W-1:0] wordA,
  input  logic [WORD_W-1:0] wordB,
  output logic [BUS_W-1:0]  dataBus,
  output logic              frameBusy,
  output logic              byteStrobe
);

  outStrobe_t       strobes;
  logic [BUS_W-1:0] curByte;
  logic             lastByte;

  byteSerialOut_ctrl #(
    .AZ_CLKS  (AZ_CLKS),
    .HOLD_CLKS(HOLD_CLKS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .calibN    (calibN),
    .fetchN    (fetchN),
    .cycleDone (cycleDone),
    .lastByte  (lastByte),
    .strobes   (strobes),
    .frameBusy (frameBusy),
    .byteStrobe(byteStrobe)
  );

  byteSerialOut_dp #(
    .WORD_W(WORD_W),
    .BUS_W (BUS_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wordA   (wordA),
    .wordB   (wordB),
    .curByte (curByte),
    .lastByte(lastByte)
  );

  assign dataBus = oeN ? 'z : curByte;

endmodule

// File: rtl/byteSerialOut_chk.sv
module byteSerialOut_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             calibN,
  input logic             cycleDone,
  input logic             frameBusy,
  input logic             byteStrobe,
  input logic [BUS_W-1:0] curByte
);

  // R5
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteStrobe |-> frameBusy);

  // R1
  calib_forces_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !calibN |=> (frameBusy && !byteStrobe));

  // R4
  byte_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteStrobe && $past(byteStrobe)) |-> $stable(curByte));

  // R4
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(byteStrobe) |-> ($past(frameBusy) && !$past(byteStrobe)));

  // R2
  ack_after_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(frameBusy) && $past(calibN)) |-> $past(cycleDone));

endmodule

bind byteSerialOut byteSerialOut_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .calibN    (calibN),
  .cycleDone (cycleDone),
  .frameBusy (frameBusy),
  .byteStrobe(byteStrobe),
  .curByte   (curByte)
);

// File: tb/test_byteSerialOut.sv
module test_byteSerialOut;

  localparam int CLK_PERIOD = 10;
  localparam int AZ_CLKS    = 8;
  localparam int HOLD_CLKS  = 2;
  localparam int NVEC       = 4;

  // {wordA, wordB, cycles between request and cycle end}
  localparam logic [71:0] VECS [NVEC] = '{
    {32'h12345678, 32'h9ABCDEF0, 8'd0},
    {32'hFFFFFFFF, 32'h00000001, 8'd3},
    {32'h80000000, 32'h7FFFFFFF, 8'd1},
    {32'h00000000, 32'hFFFFFF00, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        calibN = 1'b1;
  logic        fetchN = 1'b1;
  logic        oeN = 1'b0;
  logic        cycleDone = 1'b0;
  logic [31:0] wordA = '0;
  logic [31:0] wordB = '0;
  wire  [7:0]  busW;
  logic        frameBusy;
  logic        byteStrobe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_pu
    pullup puI (busW[g]);
  end

  byteSerialOut #(
    .WORD_W(32), .BUS_W(8), .AZ_CLKS(AZ_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) i_byteSerialOut (
    .clk(clk), .rstN(rstN), .calibN(calibN), .fetchN(fetchN), .oeN(oeN),
    .cycleDone(cycleDone), .wordA(wordA), .wordB(wordB),
    .dataBus(busW), .frameBusy(frameBusy), .byteStrobe(byteStrobe)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // count cycles of busy after calibration release (R1)
  task automatic countCalib(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (frameBusy && !byteStrobe) n++;
      else break;
    end
  endtask

  // watch busy for a while; report whether it ever rose
  task automatic watchQuiet(input int cyc, output bit rose);
    rose = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      cycleDone = (i % 4 == 1);
      if (frameBusy || byteStrobe) rose = 1'b1;
    end
    cycleDone = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] a, input logic [31:0] b, input int dly,
                      input bit keepLow);
    logic [63:0] got;
    logic [7:0]  prevBus;
    bit          prevS0;
    int          n, hi, badSetup, badHold, earlyAck;
    bit          endOk;
    got = '0; n = 0; hi = 0; badSetup = 0; badHold = 0; earlyAck = 0; endOk = 0;
    @(negedge clk);
    fetchN = 1'b1;
    wordA = a; wordB = b;
    @(negedge clk);
    fetchN = 1'b0;
    if (dly > 0) begin
      for (int i = 0; i < dly; i++) begin
        @(negedge clk);
        if (frameBusy) earlyAck++;
      end
    end
    cycleDone = 1'b1;
    @(negedge clk);
    cycleDone = 1'b0;
    // R2: acknowledge one cycle after the cycle-end pulse, not earlier
    check(earlyAck == 0 && frameBusy && !byteStrobe, "R2 ack timing",
          {earlyAck[31:0], 30'd0, frameBusy, byteStrobe}, 64'd2);
    // R10: change the inputs after capture
    wordA = ~a; wordB = ~b;
    if (!keepLow) fetchN = 1'b1;
    prevBus = busW; prevS0 = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!frameBusy) begin
        endOk = prevS0 && !byteStrobe && (hi == HOLD_CLKS);
        break;
      end
      if (byteStrobe && !prevS0) begin
        if (busW != prevBus) badSetup++;
        if (n < 8) got[63-8*n -: 8] = busW;
        n++;
        hi = 1;
      end else if (byteStrobe) begin
        if (busW != prevBus) badSetup++;
        hi++;
      end else if (prevS0) begin
        if (hi != HOLD_CLKS) badHold++;
      end
      prevS0 = byteStrobe;
      prevBus = busW;
    end
    check(got == {a, b}, "R3 R10 words rebuilt", got, {a, b});
    check(badSetup == 0, "R4 setup and hold of byte", 64'(badSetup), 64'd0);
    check(n == 8 && badHold == 0, "R5 strobe count and width",
          {32'(n), 32'(badHold)}, {32'd8, 32'd0});
    check(endOk, "R6 busy falls with last strobe", 64'(endOk), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int  n;
    bit  rose;
    // reset state
    repeat (3) @(negedge clk);
    check(frameBusy && !byteStrobe, "R1 busy during reset",
          {frameBusy, byteStrobe}, 64'd2);
    rstN = 1'b1;
    countCalib(n);
    check(n == AZ_CLKS - 1, "R1 calibration length after reset", 64'(n),
          64'(AZ_CLKS - 1));

    // table of transfers; row 0 has request and cycle end together
    for (int v = 0; v < NVEC; v++) begin
      xfer(VECS[v][71:40], VECS[v][39:8], int'(VECS[v][7:0]), v == 1);
      if (v == 1) begin
        // R8: request still low after transfer
        watchQuiet(20, rose);
        check(!rose, "R8 held request starts nothing", 64'(rose), 64'd0);
        fetchN = 1'b1;
      end
    end

    // R7: bus drive follows output enable; last byte sent was 00
    @(negedge clk);
    oeN = 1'b1;
    @(negedge clk);
    check(busW == 8'hFF, "R7 bus floats with oeN high", 64'(busW), 64'hFF);
    oeN = 1'b0;
    @(negedge clk);
    check(busW == 8'h00, "R7 bus driven with oeN low", 64'(busW), 64'h00);

    // R9: request edge during a transfer is ignored
    @(negedge clk);
    fetchN = 1'b0; cycleDone = 1'b1;
    @(negedge clk);
    cycleDone = 1'b0; fetchN = 1'b1;
    @(negedge clk);
    fetchN = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!frameBusy) break;
    end
    watchQuiet(20, rose);
    check(!rose, "R9 edge during transfer ignored", 64'(rose), 64'd0);
    fetchN = 1'b1;

    // R9: calibration aborts a transfer; edge during calibration ignored
    @(negedge clk);
    fetchN = 1'b0; cycleDone = 1'b1;
    @(negedge clk);
    cycleDone = 1'b0; fetchN = 1'b1;
    repeat (5) @(negedge clk);
    calibN = 1'b0;
    @(negedge clk);
    check(frameBusy && !byteStrobe, "R9 abort by calibration",
          {frameBusy, byteStrobe}, 64'd2);
    fetchN = 1'b0;
    @(negedge clk);
    calibN = 1'b1;
    countCalib(n);
    check(n == AZ_CLKS - 1, "R1 calibration length after calibN", 64'(n),
          64'(AZ_CLKS - 1));
    watchQuiet(20, rose);
    check(!rose, "R9 edge during calibration ignored", 64'(rose), 64'd0);

    // recovery with a fresh request
    xfer(32'hA5A55A5A, 32'h0F1E2D3C, 2, 1'b0);
    finishRun();
  end

endmodule